// File: doc/BRIEF.md
# Folding Pre-decoded Fetch Cache

This block is a small direct-mapped instruction cache in the fetch stage. Each line keeps an instruction along with the address to fetch after it. Because of that stored successor, the block can issue one instruction per cycle on hits with no next-PC adder in the loop. When a line is filled, the fill also reads the word after the instruction being cached. If that word is an unconditional jump, a call or a conditional branch, the control instruction is folded into the line of the instruction ahead of it. The line's successor then becomes the control target. The folded instruction is never fetched on its own, and it leaves no delay slot.

A folded conditional branch is predicted taken. Execute later reports the outcome. A not-taken outcome squashes the wrong-path instruction and sends fetch to the fall-through address, which the block supplied with the issued instruction. A folded call still has to write its return address. That write collides with the issuing instruction's own register-file write, so the block raises a conflict flag. A miss stalls issue while the line is filled from a simple instruction-memory port.

Instruction encoding: bits [31:30] give the kind (00 plain, 01 jump, 10 call, 11 conditional branch). Bits [AW-1:0] hold the absolute byte target, and the block forces its low two bits to zero.

Top module: `fetch_fold_cache`

## Requirements
- R1: While reset is high and on the first cycle after it, issue_valid and issue_wport_conflict are 0. The first memory read after reset is at RESET_PC.
- R2: A plain instruction whose following word is also plain issues with issue_next_pc = its address + 4, issue_fold = 00 and issue_alt_pc = its address + 4.
- R3: A jump (kind 01) following a plain instruction is folded. The plain instruction issues with issue_next_pc = jump target, issue_fold = 01 and issue_alt_pc = its address + 8. The jump's own address is never issued.
- R4: A call (kind 10) following a plain instruction is folded the same way, with issue_fold = 10 and issue_alt_pc = return address (host address + 8). issue_wport_conflict is 1 in that issue cycle and only for folded calls.
- R5: A conditional branch (kind 11) following a plain instruction is folded and predicted taken. The host issues with issue_next_pc = branch target, issue_fold = 11 and issue_alt_pc = host address + 8.
- R6: When resolve_valid is 1 with resolve_taken 0, issue_valid is 0 in the following cycle. The next issued address is resolve_alt, and the instruction on the predicted path is dropped.
- R7: A resolve with resolve_taken 1 leaves the issued stream unchanged.
- R8: On a miss, issue_valid stays 0 while mem_req is 1. The fill reads the missing address and then that address + 4, and the line is refetched after an eviction.
- R9: While all lines hit, issues come on consecutive cycles, with no memory read. Each issued address equals the previous issue_next_pc.
- R10: A control instruction found at the missing address itself is cached unfolded, with issue_next_pc = its target, issue_fold = 00 and issue_alt_pc = its address + 4. The word after it is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Fill read request |
| mem_addr | output | AW | Fill read byte address |
| mem_valid | input | 1 | Fill read data valid |
| mem_rdata | input | 32 | Fill read data |
| resolve_valid | input | 1 | Execute reports a folded-branch outcome |
| resolve_taken | input | 1 | Outcome was taken |
| resolve_alt | input | AW | Restart address for a not-taken outcome |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_pc | output | AW | Address of issued instruction |
| issue_instr | output | 32 | Issued instruction word |
| issue_next_pc | output | AW | Stored successor fetch address |
| issue_alt_pc | output | AW | Fall-through or return address of the folded instruction |
| issue_fold | output | 2 | Kind of folded control instruction (00 none) |
| issue_wport_conflict | output | 1 | Folded call needs the register write port |

## Verification
The bench builds the block with AW = 12 and IDX_BITS = 3, so there are eight lines with a 7-bit tag. A program with a handful of words then touches every fold kind, a control instruction reached directly, and a line eviction. With this small configuration a full loop fits in the cache, so the run can show back-to-back hits with zero memory reads. The loop is run three times: a cold pass with a taken resolve, a warm pass, and a pass with a not-taken resolve that squashes a cached wrong-path hit.

// File: rtl/fold_fc_pkg.sv
package fold_fc_pkg;
  localparam int unsigned INSTR_W = 32;

  typedef enum logic [1:0] {
    CF_NONE   = 2'd0,
    CF_JUMP   = 2'd1,
    CF_CALL   = 2'd2,
    CF_BRANCH = 2'd3
  } cf_kind_t;
endpackage

// File: rtl/fc_predecode.sv
module fc_predecode
  import fold_fc_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [INSTR_W-1:0] word,
  output cf_kind_t           kind,
  output logic [AW-1:0]      target
);
  logic unused_bits;
  assign unused_bits = ^{word[INSTR_W-3:AW], word[1:0]};

  always_comb begin
    kind   = cf_kind_t'(word[INSTR_W-1 -: 2]);
    target = {word[AW-1:2], 2'b00};
  end
endmodule

// File: rtl/fc_line_store.sv
module fc_line_store
  import fold_fc_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned IDX_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_BITS-1:0]    wr_idx,
  input  logic [AW-IDX_BITS-3:0] wr_tag,
  input  logic [INSTR_W-1:0]     wr_instr,
  input  logic [AW-1:0]          wr_next,
  input  cf_kind_t               wr_kind,
  input  logic [IDX_BITS-1:0]    rd_idx,
  output logic                   rd_valid,
  output logic [AW-IDX_BITS-3:0] rd_tag,
  output logic [INSTR_W-1:0]     rd_instr,
  output logic [AW-1:0]          rd_next,
  output cf_kind_t               rd_kind
);
  localparam int unsigned LINES = 1 << IDX_BITS;
  localparam int unsigned TAG_W = AW - IDX_BITS - 2;

  logic [TAG_W-1:0]   tag_q   [LINES];
  logic [INSTR_W-1:0] instr_q [LINES];
  logic [AW-1:0]      next_q  [LINES];
  logic [1:0]         kind_q  [LINES];
  logic [LINES-1:0]   valid_q;

  // Data arrays carry no reset so they map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]   <= wr_tag;
      instr_q[wr_idx] <= wr_instr;
      next_q[wr_idx]  <= wr_next;
      kind_q[wr_idx]  <= wr_kind;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_comb begin
    rd_valid = valid_q[rd_idx];
    rd_tag   = tag_q[rd_idx];
    rd_instr = instr_q[rd_idx];
    rd_next  = next_q[rd_idx];
    rd_kind  = cf_kind_t'(kind_q[rd_idx]);
  end
endmodule

// File: rtl/fetch_fold_cache.sv
module fetch_fold_cache
  import fold_fc_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned IDX_BITS = 4,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  input  logic          resolve_valid,
  input  logic          resolve_taken,
  input  logic [AW-1:0] resolve_alt,
  output logic          issue_valid,
  output logic [AW-1:0] issue_pc,
  output logic [31:0]   issue_instr,
  output logic [AW-1:0] issue_next_pc,
  output logic [AW-1:0] issue_alt_pc,
  output logic [1:0]    issue_fold,
  output logic          issue_wport_conflict
);
  localparam int unsigned TAG_W = AW - IDX_BITS - 2;
  localparam logic [AW-1:0] STEP  = AW'(4);
  localparam logic [AW-1:0] STEP2 = AW'(8);

  typedef enum logic [1:0] {ST_LOOK, ST_HEAD, ST_NEXT} fill_st_t;

  fill_st_t            st_q;
  logic [AW-1:0]       pc_q;
  logic [INSTR_W-1:0]  head_q;

  logic [IDX_BITS-1:0] idx;
  logic [TAG_W-1:0]    tag;
  logic [AW-1:0]       pc_plus4;

  logic                wr_en;
  logic [INSTR_W-1:0]  wr_instr;
  logic [AW-1:0]       wr_next;
  cf_kind_t            wr_kind;

  logic                rd_valid;
  logic [TAG_W-1:0]    rd_tag;
  logic [INSTR_W-1:0]  rd_instr;
  logic [AW-1:0]       rd_next;
  cf_kind_t            rd_kind;

  cf_kind_t            fill_kind;
  logic [AW-1:0]       fill_target;
  logic                hit;
  logic                squash;

  assign idx      = pc_q[IDX_BITS+1:2];
  assign tag      = pc_q[AW-1:IDX_BITS+2];
  assign pc_plus4 = pc_q + STEP;
  assign hit      = (st_q == ST_LOOK) && rd_valid && (rd_tag == tag);
  assign squash   = resolve_valid && !resolve_taken;

  fc_line_store #(.AW(AW), .IDX_BITS(IDX_BITS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (idx),
    .wr_tag   (tag),
    .wr_instr (wr_instr),
    .wr_next  (wr_next),
    .wr_kind  (wr_kind),
    .rd_idx   (idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_instr (rd_instr),
    .rd_next  (rd_next),
    .rd_kind  (rd_kind)
  );

  fc_predecode #(.AW(AW)) u_fill_dec (
    .word   (mem_rdata),
    .kind   (fill_kind),
    .target (fill_target)
  );

  // Fill path: head word first, then the word after it to decide folding
  always_comb begin
    mem_req  = 1'b0;
    mem_addr = pc_q;
    wr_en    = 1'b0;
    wr_instr = mem_rdata;
    wr_next  = fill_target;
    wr_kind  = CF_NONE;
    unique case (st_q)
      ST_HEAD: begin
        mem_req = 1'b1;
        // A control word at the head is cached as is, unfolded
        if (mem_valid && fill_kind != CF_NONE) wr_en = 1'b1;
      end
      ST_NEXT: begin
        mem_req  = 1'b1;
        mem_addr = pc_plus4;
        if (mem_valid) begin
          wr_en    = 1'b1;
          wr_instr = head_q;
          wr_kind  = fill_kind;
          wr_next  = (fill_kind == CF_NONE) ? pc_plus4 : fill_target;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q                 <= ST_LOOK;
      pc_q                 <= RESET_PC;
      head_q               <= '0;
      issue_valid          <= 1'b0;
      issue_pc             <= '0;
      issue_instr          <= '0;
      issue_next_pc        <= '0;
      issue_alt_pc         <= '0;
      issue_fold           <= 2'b00;
      issue_wport_conflict <= 1'b0;
    end else begin
      issue_valid          <= 1'b0;
      issue_wport_conflict <= 1'b0;
      if (squash) begin
        pc_q <= resolve_alt;
        st_q <= ST_LOOK;
      end else begin
        unique case (st_q)
          ST_LOOK: begin
            if (hit) begin
              issue_valid          <= 1'b1;
              issue_pc             <= pc_q;
              issue_instr          <= rd_instr;
              issue_next_pc        <= rd_next;
              issue_fold           <= rd_kind;
              issue_alt_pc         <= (rd_kind != CF_NONE) ? pc_q + STEP2 : pc_plus4;
              issue_wport_conflict <= (rd_kind == CF_CALL);
              pc_q                 <= rd_next;
            end else begin
              st_q <= ST_HEAD;
            end
          end
          ST_HEAD: begin
            if (mem_valid) begin
              head_q <= mem_rdata;
              st_q   <= (fill_kind != CF_NONE) ? ST_LOOK : ST_NEXT;
            end
          end
          ST_NEXT: begin
            if (mem_valid) st_q <= ST_LOOK;
          end
          default: st_q <= ST_LOOK;
        endcase
      end
    end
  end
endmodule

// File: rtl/fetch_fold_cache_chk.sv
module fetch_fold_cache_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          resolve_valid,
  input logic          resolve_taken,
  input logic          issue_valid,
  input logic [AW-1:0] issue_pc,
  input logic [31:0]   issue_instr,
  input logic [AW-1:0] issue_next_pc,
  input logic [1:0]    issue_fold,
  input logic          issue_wport_conflict
);
  logic unused_instr;
  assign unused_instr = ^{issue_instr[29:AW], issue_instr[1:0]};

  assert_conflict_only_call_R4: assert property (@(posedge clk) disable iff (rst)
    issue_wport_conflict |-> (issue_valid && issue_fold == 2'b10));

  assert_squash_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    (resolve_valid && !resolve_taken) |=> !issue_valid);

  assert_stall_on_fill_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !issue_valid);

  assert_chain_next_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && $past(issue_valid)) |-> issue_pc == $past(issue_next_pc));

  assert_plain_step_R2: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_fold == 2'b00 && issue_instr[31:30] == 2'b00)
      |-> issue_next_pc == issue_pc + AW'(4));

  assert_direct_target_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_fold == 2'b00 && issue_instr[31:30] != 2'b00)
      |-> issue_next_pc == {issue_instr[AW-1:2], 2'b00});

  assert_fold_host_plain_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_fold != 2'b00) |-> issue_instr[31:30] == 2'b00);
endmodule

bind fetch_fold_cache fetch_fold_cache_chk #(.AW(AW)) u_chk (.*);

// File: tb/fetch_fold_cache_bench.sv
module fetch_fold_cache_bench;
  localparam int unsigned AW  = 12;
  localparam int unsigned IDX = 3;

  logic          clk;
  logic          rst;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_valid;
  logic [31:0]   mem_rdata;
  logic          resolve_valid;
  logic          resolve_taken;
  logic [AW-1:0] resolve_alt;
  logic          issue_valid;
  logic [AW-1:0] issue_pc;
  logic [31:0]   issue_instr;
  logic [AW-1:0] issue_next_pc;
  logic [AW-1:0] issue_alt_pc;
  logic [1:0]    issue_fold;
  logic          issue_wport_conflict;

  int checks = 0;
  int errors = 0;
  int reads = 0;
  int a4_reads = 0;

  fetch_fold_cache #(.AW(AW), .IDX_BITS(IDX), .RESET_PC(12'h000)) u_fetch_fold_cache (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .resolve_valid(resolve_valid), .resolve_taken(resolve_taken), .resolve_alt(resolve_alt),
    .issue_valid(issue_valid), .issue_pc(issue_pc), .issue_instr(issue_instr),
    .issue_next_pc(issue_next_pc), .issue_alt_pc(issue_alt_pc),
    .issue_fold(issue_fold), .issue_wport_conflict(issue_wport_conflict)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Program image: kind in [31:30], absolute target in the low bits
  function automatic logic [31:0] prog(input logic [AW-1:0] a);
    case (a)
      12'h004: prog = {2'b01, 14'h0, 16'h0028};
      12'h02C: prog = {2'b10, 14'h0, 16'h0050};
      12'h054: prog = {2'b11, 14'h0, 16'h0078};
      12'h080: prog = {2'b01, 14'h0, 16'h0000};
      12'h05C: prog = {2'b01, 14'h0, 16'h00A0};
      12'h0A0: prog = {2'b01, 14'h0, 16'h0000};
      default: prog = {2'b00, 14'h1555, 4'h0, a};
    endcase
  endfunction

  assign mem_valid = mem_req;
  assign mem_rdata = prog(mem_addr);

  always @(negedge clk) begin
    if (!rst && mem_req) begin
      reads++;
      if (mem_addr == 12'h0A4) a4_reads++;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_issue(input string req, input logic [AW-1:0] epc, input logic [AW-1:0] enext,
                              input logic [AW-1:0] ealt, input logic [1:0] efold, input logic econf,
                              output int waited);
    waited = 0;
    do begin
      @(negedge clk);
      resolve_valid = 1'b0;
      waited++;
    end while (!issue_valid && waited < 60);
    chk(req, "issue_valid", 32'(issue_valid), 32'd1);
    chk(req, "issue_pc", 32'(issue_pc), 32'(epc));
    chk(req, "issue_next_pc", 32'(issue_next_pc), 32'(enext));
    chk(req, "issue_alt_pc", 32'(issue_alt_pc), 32'(ealt));
    chk(req, "issue_fold", 32'(issue_fold), 32'(efold));
    chk(req, "issue_wport_conflict", 32'(issue_wport_conflict), 32'(econf));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int w;
    int base;
    rst = 1'b1;
    resolve_valid = 1'b0;
    resolve_taken = 1'b0;
    resolve_alt = '0;
    repeat (3) @(negedge clk);
    chk("R1", "issue_valid in reset", 32'(issue_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "issue_valid after reset", 32'(issue_valid), 32'd0);
    chk("R1", "conflict after reset", 32'(issue_wport_conflict), 32'd0);
    chk("R1", "first mem_req", 32'(mem_req), 32'd1);
    chk("R1", "first mem_addr", 32'(mem_addr), 32'h000);
    @(negedge clk);
    chk("R8", "second fill read", 32'(mem_addr), 32'h004);
    chk("R8", "stall during fill", 32'(issue_valid), 32'd0);

    // Cold pass, folded branch resolves taken
    expect_issue("R3", 12'h000, 12'h028, 12'h008, 2'b01, 1'b0, w);
    expect_issue("R4", 12'h028, 12'h050, 12'h030, 2'b10, 1'b1, w);
    expect_issue("R5", 12'h050, 12'h078, 12'h058, 2'b11, 1'b0, w);
    resolve_valid = 1'b1;
    resolve_taken = 1'b1;
    resolve_alt   = 12'h058;
    expect_issue("R7", 12'h078, 12'h07C, 12'h07C, 2'b00, 1'b0, w);
    expect_issue("R2", 12'h07C, 12'h000, 12'h084, 2'b01, 1'b0, w);

    // Warm pass: back-to-back hits, no memory traffic
    base = reads;
    expect_issue("R9", 12'h000, 12'h028, 12'h008, 2'b01, 1'b0, w);
    chk("R9", "hit spacing 000", 32'(w), 32'd1);
    expect_issue("R9", 12'h028, 12'h050, 12'h030, 2'b10, 1'b1, w);
    chk("R9", "hit spacing 028", 32'(w), 32'd1);
    expect_issue("R9", 12'h050, 12'h078, 12'h058, 2'b11, 1'b0, w);
    chk("R9", "hit spacing 050", 32'(w), 32'd1);
    expect_issue("R9", 12'h078, 12'h07C, 12'h07C, 2'b00, 1'b0, w);
    chk("R9", "hit spacing 078", 32'(w), 32'd1);
    expect_issue("R9", 12'h07C, 12'h000, 12'h084, 2'b01, 1'b0, w);
    chk("R9", "hit spacing 07C", 32'(w), 32'd1);
    chk("R9", "reads during warm pass", 32'(reads - base), 32'd0);

    // Third pass: branch resolves not taken
    expect_issue("R9", 12'h000, 12'h028, 12'h008, 2'b01, 1'b0, w);
    expect_issue("R9", 12'h028, 12'h050, 12'h030, 2'b10, 1'b1, w);
    expect_issue("R5", 12'h050, 12'h078, 12'h058, 2'b11, 1'b0, w);
    resolve_valid = 1'b1;
    resolve_taken = 1'b0;
    resolve_alt   = 12'h058;
    @(negedge clk);
    resolve_valid = 1'b0;
    chk("R6", "squash bubble", 32'(issue_valid), 32'd0);
    expect_issue("R6", 12'h058, 12'h0A0, 12'h060, 2'b01, 1'b0, w);
    expect_issue("R10", 12'h0A0, 12'h000, 12'h0A4, 2'b00, 1'b0, w);
    chk("R10", "word after direct jump read", 32'(a4_reads), 32'd0);
    base = reads;
    expect_issue("R8", 12'h000, 12'h028, 12'h008, 2'b01, 1'b0, w);
    chk("R8", "refill after eviction reads", 32'(reads - base), 32'd2);

    summary();
    $finish;
  end
endmodule